// File: doc/BRIEF.md
# Masked Pin-Change Interrupt Unit

This unit watches thirteen general-purpose pad inputs and turns any change on them into one of two interrupt requests. Pins 7..0 belong to group 0 and pins 12..8 belong to group 1. Each group has a per-pin mask, so only the selected pins count. A rise and a fall are treated alike. A qualifying change latches that group's flag. The flag raises the group's request line while the group is enabled.

The pad value is sampled whatever the pin's direction, so software can drive a pin configured as an output to raise an interrupt on purpose. A two-flop synchroniser feeds the clocked detection path. A separate combinational wake output compares the live pad against the value captured at the last clock edge. It stays valid while the clock is stopped, so a power controller can use it to restart the clock.

Top module: `pcint_unit`

## Requirements
- R1: After reset, all flags, both masks and both group enables are zero. `irq_o` and `wake_o` are low and every register reads zero.
- R2: Register map, selected by `reg_addr_i` and written when `reg_we_i` is high:
  - Address 0 is the group 0 mask. Bit n selects pin n.
  - Address 1 is the group 1 mask. Bits 4..0 select pins 12..8 and bits 7..5 read as zero.
  - Address 2 holds the flags: bit 0 for group 0 and bit 1 for group 1.
  - Address 3 holds the group enables in bits 1..0.
  - `reg_rdata_o` shows the selected register combinationally.
- R3: A rising or falling change on a pin whose mask bit is set sets its group's flag on the third rising clock edge after the change.
- R4: A change on a pin whose mask bit is clear sets no flag. A change in one group never sets the other group's flag.
- R5: Setting a mask bit while the pins are steady sets no flag.
- R6: Writing address 2 clears each flag whose data bit is 1 and leaves alone each flag whose data bit is 0.
- R7: A high `irq_ack_i[g]` at a clock edge clears flag g.
- R8: `irq_o[g]` is high exactly when flag g and enable g are both set. A flag that is already pending raises the request once the group is enabled.
- R9: When a qualifying change arrives in the same cycle as a clear (write-one or acknowledge), the flag stays set.
- R10: `wake_o[g]` goes high without any clock edge while an enabled pin of group g differs from its value at the last clock edge. It falls once an edge captures the new value. Pins that are masked off never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 13 | Pad values of the monitored pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_ack_i | input | 2 | Per-group request acknowledge; clears the flag |
| irq_o | output | 2 | Per-group interrupt request |
| wake_o | output | 2 | Per-group combinational wake indication |

## Verification
The bench builds the unit with its default split: 13 pins, 8 of them in group 0, and an 8-bit data path. Group 0 then fills the data word exactly, while group 1 is narrower and leaves unused read bits, so both the full-width and the zero-padded mask paths are covered. The short synchroniser keeps the three-edge latency and the change-meets-clear collision reachable with exact cycle placement. Random mask, enable and pin patterns, checked against a bench model, then cover the group split.

// File: rtl/pcint_pkg.sv
`timescale 1ns/1ps
package pcint_pkg;
  localparam int NUM_GROUPS = 2;

  typedef enum logic [1:0] {
    REG_MASK0 = 2'd0,
    REG_MASK1 = 2'd1,
    REG_FLAG  = 2'd2,
    REG_GEN   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pcint_sync.sv
`timescale 1ns/1ps
module pcint_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gen_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcint_group.sv
`timescale 1ns/1ps
module pcint_group #(
  parameter int W      = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      pin_raw_i,
  input  logic [W-1:0]      pin_sync_i,
  input  logic              mask_we_i,
  input  logic [W-1:0]      mask_wdata_i,
  input  logic              flag_clr_i,
  output logic              hit_o,
  output logic              flag_o,
  output logic              wake_o,
  output logic [DATA_W-1:0] mask_rd_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] prev_q;   // last synchronised value, updated for every pin
  logic [W-1:0] snap_q;   // raw pad value at last edge, held when clock stops
  logic         flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      prev_q <= '0;
      snap_q <= '0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      prev_q <= pin_sync_i;
      snap_q <= pin_raw_i;
    end
  end

  assign hit_o = |((pin_sync_i ^ prev_q) & mask_q);

  // a new change wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (hit_o)      flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign wake_o = |((pin_raw_i ^ snap_q) & mask_q);

  always_comb begin
    mask_rd_o = '0;
    mask_rd_o[W-1:0] = mask_q;
  end
endmodule

// File: rtl/pcint_unit.sv
`timescale 1ns/1ps
module pcint_unit #(
  parameter int NUM_PINS = 13,
  parameter int G0_PINS  = 8,
  parameter int DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [1:0]          irq_ack_i,
  output logic [1:0]          irq_o,
  output logic [1:0]          wake_o
);
  import pcint_pkg::*;

  localparam int G1_PINS = NUM_PINS - G0_PINS;
  localparam int NG      = NUM_GROUPS;

  logic [NUM_PINS-1:0]    pin_sync_w;
  logic [NG-1:0]          hit_w;
  logic [NG-1:0]          flag_w;
  logic [NG-1:0]          flag_clr_w;
  logic [NG-1:0]          gen_q;
  logic [NG*DATA_W-1:0]   mask_rd_w;

  pcint_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync_w)
  );

  for (genvar g = 0; g < NG; g++) begin : gen_grp
    localparam int GW  = (g == 0) ? G0_PINS : G1_PINS;
    localparam int GLO = (g == 0) ? 0 : G0_PINS;

    assign flag_clr_w[g] = irq_ack_i[g] |
                           (reg_we_i && reg_addr_i == REG_FLAG && reg_wdata_i[g]);

    pcint_group #(.W(GW), .DATA_W(DATA_W)) u_grp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_raw_i   (pin_i[GLO +: GW]),
      .pin_sync_i  (pin_sync_w[GLO +: GW]),
      .mask_we_i   (reg_we_i && reg_addr_i == 2'(g)),
      .mask_wdata_i(reg_wdata_i[GW-1:0]),
      .flag_clr_i  (flag_clr_w[g]),
      .hit_o       (hit_w[g]),
      .flag_o      (flag_w[g]),
      .wake_o      (wake_o[g]),
      .mask_rd_o   (mask_rd_w[g*DATA_W +: DATA_W])
    );

    assign irq_o[g] = flag_w[g] & gen_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gen_q <= '0;
    else if (reg_we_i && reg_addr_i == REG_GEN) gen_q <= reg_wdata_i[NG-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_MASK0: reg_rdata_o = mask_rd_w[0 +: DATA_W];
      REG_MASK1: reg_rdata_o = mask_rd_w[DATA_W +: DATA_W];
      REG_FLAG:  reg_rdata_o[NG-1:0] = flag_w;
      default:   reg_rdata_o[NG-1:0] = gen_q;
    endcase
  end
endmodule

// File: rtl/pcint_unit_chk.sv
`timescale 1ns/1ps
module pcint_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [1:0]        irq_ack_i,
  input logic [1:0]        irq_i,
  input logic [1:0]        wake_i,
  input logic [1:0]        hit_i,
  input logic [1:0]        flag_i,
  input logic [2*DATA_W-1:0] mask_i
);
  logic [1:0] w1c;
  assign w1c = (reg_we_i && reg_addr_i == 2'd2) ? reg_wdata_i[1:0] : 2'b00;

  p_flag_rise_r3_g0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i[0]) |-> $past(hit_i[0]));
  p_flag_rise_r3_g1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i[1]) |-> $past(hit_i[1]));
  p_hit_wins_r9_g0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i[0] |=> flag_i[0]);
  p_hit_wins_r9_g1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i[1] |=> flag_i[1]);
  p_w1c_r6_g0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1c[0] && !hit_i[0] |=> !flag_i[0]);
  p_w1c_r6_g1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1c[1] && !hit_i[1] |=> !flag_i[1]);
  p_hold_r6_g0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i[0] && !w1c[0] && !irq_ack_i[0] |=> flag_i[0]);
  p_ack_r7_g0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i[0] && !hit_i[0] |=> !flag_i[0]);
  p_ack_r7_g1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i[1] && !hit_i[1] |=> !flag_i[1]);
  p_irq_flag_r8_g0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[0] |-> flag_i[0]);
  p_irq_flag_r8_g1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[1] |-> flag_i[1]);
  p_no_hit_unmasked_r4_g1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i[DATA_W +: DATA_W] == '0) |-> !hit_i[1]);
  p_wake_mask_r10_g0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i[0] |-> (mask_i[0 +: DATA_W] != '0));
  p_wake_mask_r10_g1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i[1] |-> (mask_i[DATA_W +: DATA_W] != '0));
endmodule

bind pcint_unit pcint_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_ack_i  (irq_ack_i),
  .irq_i      (irq_o),
  .wake_i     (wake_o),
  .hit_i      (hit_w),
  .flag_i     (flag_w),
  .mask_i     (mask_rd_w)
);

// File: tb/pcint_unit_tb.sv
`timescale 1ns/1ps
module pcint_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] pin = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  ack = '0;
  logic [1:0]  irq;
  logic [1:0]  wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m0 = '0;
  logic [4:0] m1 = '0;
  logic [1:0] en = '0;
  logic [1:0] exp_flag = '0;

  always #5 clk = ~clk;

  pcint_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_ack_i(ack), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [1:0] grp_hit(input logic [12:0] o, input logic [12:0] n,
                                          input logic [7:0] k0, input logic [4:0] k1);
    logic [12:0] d;
    d = o ^ n;
    return {|(d[12:8] & k1), |(d[7:0] & k0)};
  endfunction

  function automatic logic [1:0] wake_exp(input logic [12:0] o, input logic [12:0] n,
                                           input logic [7:0] k0, input logic [4:0] k1);
    return grp_hit(o, n, k0, k1);
  endfunction

  task automatic set_pins(input logic [12:0] v);
    logic [12:0] old;
    old = pin;
    @(negedge clk); pin = v; #1;
    chk(wake === wake_exp(old, v, m0, m1), "R10 wake", wake, wake_exp(old, v, m0, m1));
    exp_flag |= grp_hit(old, v, m0, m1);
    @(posedge clk); #1;
    chk(wake === 2'b00, "R10 wake drop", wake, 0);
    cyc(4);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd2024));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk(r === 8'h00, "R1 reset read", r, 0);
    end
    chk(irq === 2'b00 && wake === 2'b00, "R1 reset outputs", {irq, wake}, 0);

    // R2 register map
    wr(2'd0, 8'hA5); wr(2'd1, 8'hFF); wr(2'd3, 8'h02);
    rd(2'd0, r); chk(r === 8'hA5, "R2 mask0", r, 8'hA5);
    rd(2'd1, r); chk(r === 8'h1F, "R2 mask1 width", r, 8'h1F);
    rd(2'd3, r); chk(r === 8'h02, "R2 enable", r, 8'h02);

    // R3 latency, rising edge
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00); wr(2'd3, 8'h03);
    m0 = 8'hFF; m1 = 5'h00; en = 2'b11;
    @(negedge clk); pin[3] = 1'b1;
    @(negedge clk); chk(irq[0] === 1'b0, "R3 edge 1", irq, 0);
    @(negedge clk); chk(irq[0] === 1'b0, "R3 edge 2", irq, 0);
    @(negedge clk); chk(irq[0] === 1'b1, "R3 edge 3", irq, 1);
    // R7 ack clears
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    chk(irq[0] === 1'b0, "R7 ack", irq, 0);
    // R3 falling edge
    @(negedge clk); pin[3] = 1'b0;
    cyc(3); chk(irq[0] === 1'b1, "R3 fall", irq, 1);
    // R9 change meets clear
    @(negedge clk); pin[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    chk(irq[0] === 1'b1, "R9 set wins over ack", irq, 1);
    // R6 write-one-to-clear, zero bits keep
    wr(2'd2, 8'h02); rd(2'd2, r); chk(r === 8'h01, "R6 w1c zero keeps", r, 1);
    wr(2'd2, 8'h01); rd(2'd2, r); chk(r === 8'h00, "R6 w1c clears", r, 0);

    // R4 masked pins and group isolation
    wr(2'd0, 8'h0F); wr(2'd1, 8'h02); m0 = 8'h0F; m1 = 5'h02;
    exp_flag = '0;
    set_pins(pin ^ 13'h0020);
    rd(2'd2, r); chk(r === 8'h00, "R4 masked pin", r, 0);
    set_pins(pin ^ 13'h0200);
    rd(2'd2, r); chk(r === 8'h02, "R4 group isolation", r, 2);
    wr(2'd2, 8'h03); exp_flag = '0;

    // R5 mask change on steady pins
    set_pins(13'h1ABC); wr(2'd2, 8'h03); exp_flag = '0;
    wr(2'd0, 8'hFF); wr(2'd1, 8'h1F); m0 = 8'hFF; m1 = 5'h1F;
    cyc(5); rd(2'd2, r); chk(r === 8'h00, "R5 mask change", r, 0);

    // R8 pending flag then enable
    wr(2'd3, 8'h00); en = 2'b00;
    set_pins(pin ^ 13'h1001);
    chk(irq === 2'b00, "R8 disabled", irq, 0);
    wr(2'd3, 8'h03); #1;
    chk(irq === 2'b11, "R8 late enable", irq, 3);
    wr(2'd2, 8'h03); exp_flag = '0;

    // random phase
    for (int it = 0; it < 300; it++) begin
      logic [12:0] nv;
      m0 = 8'($urandom); m1 = 5'($urandom); en = 2'($urandom);
      wr(2'd0, m0); wr(2'd1, {3'b0, m1}); wr(2'd3, {6'b0, en});
      nv = pin ^ (13'($urandom) & 13'($urandom));
      set_pins(nv);
      rd(2'd2, r); chk(r[1:0] === exp_flag, "R3 random flags", r, exp_flag);
      #1; chk(irq === (exp_flag & en), "R8 random irq", irq, exp_flag & en);
      case ($urandom % 3)
        0: begin
          logic [1:0] c; c = 2'($urandom);
          wr(2'd2, {6'b0, c}); exp_flag &= ~c;
        end
        1: begin
          logic [1:0] c; c = 2'($urandom);
          @(negedge clk); ack = c; @(negedge clk); ack = 2'b00; exp_flag &= ~c;
        end
        default: ;
      endcase
      rd(2'd2, r); chk(r[1:0] === exp_flag, "R6 R7 random clear", r, exp_flag);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule